// File: doc/BRIEF.md
# Byte-Addressed Countdown Timer

This block is a 16-bit unsigned countdown timer. A processor reaches it through a narrow register bus made of an address, write data, a write strobe, a read strobe and read data. The count sits behind two adjacent 8-bit offsets: offset 0 is the low byte and offset 1 is the high byte. A third offset holds control and status. An external one-cycle tick pulse, nominally fifty per second, lowers the count by one while the timer is enabled. The tick that brings the count to zero raises a sticky interrupt request. Software clears that request by writing to the status offset.

Software must reach a 16-bit value through two byte accesses, and a tick can fall between them. The block guards both directions against that race. A low-byte write only fills a holding latch. The high-byte write then loads all 16 bits in a single cycle. A low-byte read freezes the current high byte in a shadow register, and the next high-byte read returns that shadow. The bus has no back-pressure: every access finishes in one clock cycle, there is no ready signal, and a strobe may be held for one cycle only per access. Read data is registered and becomes valid one clock cycle after the read strobe is sampled.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count is 0x0000, the enable bit is 0, the interrupt flag is 0 and `irq` is low. A read of offset 2 returns 0x00.
- R2: A write to offset 0 leaves the count unchanged and only fills the low-byte latch. A write to offset 1 loads the count with the written byte in bits 15..8 and the latched byte in bits 7..0.
- R3: While enabled, each tick lowers the count by exactly one. When the low byte passes from 0x00 to 0xFF, the high byte falls by one in the same step (0x0100 becomes 0x00FF).
- R4: While the enable bit (offset 2, bit 0) is 0, ticks leave the count unchanged.
- R5: A tick in the same cycle as a write to offset 1 is ignored, so the count equals the written value.
- R6: A tick that falls between the offset 0 write and the offset 1 write does not alter the value that is loaded.
- R7: A read of offset 0 returns the live low byte and captures the high byte into a shadow register. A read of offset 1 returns that shadow, even if ticks have changed the count since.
- R8: The tick that takes the count from 1 to 0 sets the interrupt flag. The flag then stays set, and `irq` follows it.
- R9: While the count is zero, ticks keep it at zero and do not set the flag again.
- R10: A write to offset 2 sets the enable bit from data bit 0. A 1 in data bit 1 clears the flag, and a 0 in that bit leaves the flag alone. A read of offset 2 returns enable in bit 0, the flag in bit 1, and zero in the other bits.
- R11: If the flag is set and cleared in the same cycle, the set wins.
- R12: A read of offset 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid one cycle after the read strobe |
| tick | input | 1 | One-cycle count pulse |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is a count decrement and the atomic high-byte load. The second pair is setting the flag on the last tick and software clearing it. The bench raises the tick strobe on exactly the cycle that carries the offset 1 write, and separately on the cycle that carries a flag-clearing control write while the count is 1. It then judges each case by the count read back, where the load must win, and by `irq`, where the set must win. Ticks placed between the two halves of a write and between the two halves of a read cover the torn-value races.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Register offsets; the low/high pairing is part of the access protocol.
  localparam int unsigned OFS_LO  = 0;
  localparam int unsigned OFS_HI  = 1;
  localparam int unsigned OFS_CTL = 2;

  // Control/status bit positions at OFS_CTL.
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned FLAG_BIT = 1;

  // Decoded bus access, at most one field set per cycle.
  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic wr_ctl;
    logic rd_lo;
    logic rd_hi;
    logic rd_ctl;
    logic rd_pad;
  } cdt_acc_t;
endpackage

// File: rtl/cdt_bus_decode.sv
module cdt_bus_decode
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output cdt_acc_t          acc
);
  logic hit_lo, hit_hi, hit_ctl;

  assign hit_lo  = (addr == ADDR_W'(OFS_LO));
  assign hit_hi  = (addr == ADDR_W'(OFS_HI));
  assign hit_ctl = (addr == ADDR_W'(OFS_CTL));

  always_comb begin
    acc        = '0;
    acc.wr_lo  = wr_en & hit_lo;
    acc.wr_hi  = wr_en & hit_hi;
    acc.wr_ctl = wr_en & hit_ctl;
    acc.rd_lo  = rd_en & hit_lo;
    acc.rd_hi  = rd_en & hit_hi;
    acc.rd_ctl = rd_en & hit_ctl;
    acc.rd_pad = rd_en & ~(hit_lo | hit_hi | hit_ctl);
  end
endmodule

// File: rtl/cdt_load_stage.sv
module cdt_load_stage #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  logic [BYTE_W-1:0] lo_hold;

  // Low half waits here; the count is untouched until the high half arrives.
  always_ff @(posedge clk) begin
    if (!rst_n)     lo_hold <= '0;
    else if (wr_lo) lo_hold <= wdata;
  end

  assign load     = wr_hi;
  assign load_val = {wdata, lo_hold};

  p_latch_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_hold == $past(wdata)));

  p_latch_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(lo_hold));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             clr_req,
  output logic [CNT_W-1:0] count,
  output logic             enable,
  output logic             flag
);
  logic tick_go, at_zero, at_one, fire;

  assign tick_go = tick & enable;
  assign at_zero = (count == '0);
  assign at_one  = (count == CNT_W'(1));
  assign fire    = ~load & tick_go & at_one;

  // Load outranks a tick: the written value lands exactly.
  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (load)                count <= load_val;
    else if (tick_go && !at_zero) count <= count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     enable <= 1'b0;
    else if (en_wr) enable <= en_val;
  end

  // Setting outranks clearing so a fresh expiry is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (fire)    flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  p_load_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && enable && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !enable) |=> $stable(count));

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> (count == '0));

  p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && enable && count == CNT_W'(1)) |=> flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(tick && enable && count == CNT_W'(1) && !load)) |=> !flag);
endmodule

// File: rtl/cdt_read_port.sv
module cdt_read_port
  import cdt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cdt_acc_t          acc,
  input  logic [CNT_W-1:0]  count,
  input  logic              enable,
  input  logic              flag,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] hi_shadow;
  logic [BYTE_W-1:0] ctl_word;

  always_comb begin
    ctl_word           = '0;
    ctl_word[EN_BIT]   = enable;
    ctl_word[FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_shadow <= '0;
    else if (acc.rd_lo) hi_shadow <= count[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rdata <= '0;
    else if (acc.rd_lo)   rdata <= count[BYTE_W-1:0];
    else if (acc.rd_hi)   rdata <= hi_shadow;
    else if (acc.rd_ctl)  rdata <= ctl_word;
    else if (acc.rd_pad)  rdata <= '0;
  end

  p_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc.rd_lo |=> (hi_shadow == $past(count[CNT_W-1:BYTE_W])));

  p_hi_coherent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc.rd_hi |=> (rdata == $past(hi_shadow)));

  p_pad_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc.rd_pad |=> (rdata == '0));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tick,
  output logic              irq
);
  cdt_acc_t         acc;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             enable;
  logic             flag;

  cdt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .acc   (acc)
  );

  cdt_load_stage #(.BYTE_W(BYTE_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (acc.wr_lo),
    .wr_hi    (acc.wr_hi),
    .wdata    (wdata),
    .load     (load),
    .load_val (load_val)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .en_wr    (acc.wr_ctl),
    .en_val   (wdata[EN_BIT]),
    .clr_req  (acc.wr_ctl & wdata[FLAG_BIT]),
    .count    (count),
    .enable   (enable),
    .flag     (flag)
  );

  cdt_read_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .count  (count),
    .enable (enable),
    .flag   (flag),
    .rdata  (rdata)
  );

  assign irq = flag;

  p_irq_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .tick(tick), .irq(irq)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk); addr = a; rd_en = 1'b1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load16(input logic [15:0] v);
    wr_reg(2'd0, v[7:0]);
    wr_reg(2'd1, v[15:8]);
  endtask

  task automatic read16(input logic [15:0] v, input string tag);
    rd_reg(2'd0, v[7:0], tag);
    rd_reg(2'd1, v[15:8], tag);
  endtask

  // Monitor: pops an expected item for every read accepted at a clock edge.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        item_t it;
        #1;
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: read with no expectation, actual 0x%02h expected none", rdata);
        end else begin
          it = sb.pop_front();
          check8(rdata, it.exp, it.tag);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check8({7'b0, irq}, 8'h00, "R1 irq after reset");
    rd_reg(2'd2, 8'h00, "R1 control after reset");
    read16(16'h0000, "R1 count after reset");

    // R2 staged load
    wr_reg(2'd0, 8'h34);
    read16(16'h0000, "R2 low write alone leaves count");
    wr_reg(2'd1, 8'h12);
    read16(16'h1234, "R2 high write loads both bytes");

    // R4 ticks ignored while disabled
    pulse(3);
    read16(16'h1234, "R4 disabled ticks");

    // R3 decrement and borrow
    wr_reg(2'd2, 8'h01);
    pulse(1);
    read16(16'h1233, "R3 single decrement");
    load16(16'h0100);
    pulse(1);
    read16(16'h00FF, "R3 borrow into high byte");

    // R6 tick between the two write halves
    wr_reg(2'd0, 8'h00);
    pulse(1);
    wr_reg(2'd1, 8'h05);
    read16(16'h0500, "R6 tick between write halves");

    // R5 tick coincides with the load
    wr_reg(2'd0, 8'h22);
    wr_tick(2'd1, 8'h11);
    read16(16'h1122, "R5 tick on load cycle");

    // R7 tick between the two read halves
    load16(16'h0100);
    rd_reg(2'd0, 8'h00, "R7 live low byte");
    pulse(1);
    rd_reg(2'd1, 8'h01, "R7 shadow high byte");
    read16(16'h00FF, "R7 fresh pair after tick");

    // R8 expiry sets the sticky flag
    load16(16'h0002);
    pulse(1);
    check8({7'b0, irq}, 8'h00, "R8 irq low at count 1");
    pulse(1);
    check8({7'b0, irq}, 8'h01, "R8 irq on reaching zero");
    rd_reg(2'd2, 8'h03, "R8 status shows flag");

    // R9 hold at zero; R10 clear semantics
    pulse(2);
    read16(16'h0000, "R9 count stays zero");
    wr_reg(2'd2, 8'h01);
    check8({7'b0, irq}, 8'h01, "R10 zero in clear bit keeps flag");
    wr_reg(2'd2, 8'h03);
    check8({7'b0, irq}, 8'h00, "R10 clear bit drops flag");
    rd_reg(2'd2, 8'h01, "R10 status after clear");
    pulse(2);
    check8({7'b0, irq}, 8'h00, "R9 no re-fire at zero");
    read16(16'h0000, "R9 count still zero");

    // R11 set and clear together
    load16(16'h0001);
    wr_tick(2'd2, 8'h03);
    check8({7'b0, irq}, 8'h01, "R11 set beats clear");
    rd_reg(2'd2, 8'h03, "R11 status after collision");

    // R12 unused offset
    rd_reg(2'd3, 8'h00, "R12 unused offset reads zero");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule